// File: doc/BRIEF.md
# I2C Target Register Port

This block is an I2C target front end that gives a bus controller read and write access to a small register file. It runs entirely on the system clock. It samples the SCL and SDA wires through synchronisers and finds start, repeated start and stop conditions from the sampled levels. On the register side it drives a plain port with an address, write data, a one-cycle write strobe and a read strobe. Read data comes back combinationally on the same port.

The 7-bit target address has two parts. The upper four bits are a parameter. The lower three bits are captured from a select input on the first clock after reset is released. After the control byte, the first byte of a write loads the register pointer, and every following byte is written at the pointer. The pointer then advances and wraps at the top of the register space. A read starts with a write that sets the pointer, followed by a repeated start and a control byte with the read bit set. The target then shifts out consecutive registers for as long as the controller acknowledges.

A byte is written to the register file only after its acknowledge clock has ended. A stop or repeated start that cuts a byte short therefore leaves the register file and the pointer untouched.

Top module: `i2c_reg_target`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start received at any point, including a repeated start in the middle of a transfer, begins a new control byte.
- R2: A control byte whose upper 7 bits (MSB first) differ from {TGT_PREFIX (default 4'b0100), latched select} gets no acknowledge. The target then drives nothing and writes nothing until the next start.
- R3: The select value is captured from addr_sel_i on the first clock after rst_ni is released. Changes to addr_sel_i after that have no effect on address matching.
- R4: In a write transaction, the target acknowledges the control byte, the pointer byte and every data byte by holding SDA low during the ninth SCL clock.
- R5: The first byte after a matching write control byte (bit 0 = 0) loads the pointer from its low REG_AW bits. Each later byte is written to the register at the pointer, and the pointer then advances by one. A write is a single-cycle reg_we_o pulse with reg_addr_o and reg_wdata_o valid, issued after the falling SCL edge that ends the acknowledge clock.
- R6: The pointer wraps from 2^REG_AW-1 (31 by default) to 0, for both writes and reads.
- R7: A stop or repeated start that arrives before a data byte and its acknowledge clock are complete causes no write and leaves the pointer unchanged.
- R8: After a matching control byte with bit 0 = 1, the target shifts out the register at the pointer, MSB first. It pulses reg_re_o in the cycle it captures reg_rdata_i, and the pointer advances by one for each byte loaded.
- R9: Read output continues while the controller acknowledges. A not-acknowledge ends the output, and SDA stays released until the next start.
- R10: The target changes its SDA drive only while SCL is low, and it drives nothing while in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel_i | input | SEL_W (3) | Low target address bits, captured after reset |
| reg_addr_o | output | REG_AW (5) | Register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | Register write strobe, one cycle |
| reg_re_o | output | 1 | Register read strobe, in the cycle read data is captured |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o |

## Verification
Two events can meet at the end of a data byte: the commit of that byte, and a stop or repeated start from the controller. The bench cuts a byte short after a few bits, once with a stop and once with a repeated start. It then reads the neighbouring registers and the pointer position back over the bus and counts write strobes, so a byte committed too early shows up both as a changed register and as an extra strobe. Random write and read-back bursts, some of which wrap the pointer, are compared against a register model kept by the bench.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_PTR,
    ST_WR,
    ST_RD
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // SCL high on both samples so an SCL edge is never read as a condition
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_addr_latch.sv
module i2c_addr_latch #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_o
);
  logic done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      sel_o  <= '0;
    end else if (!done_q) begin
      done_q <= 1'b1;
      sel_o  <= sel_i;
    end
  end

  AST_SEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> $stable(sel_o)); // R3
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_tgt_pkg::*;
#(
  parameter int                  PREFIX_W   = 4,
  parameter logic [PREFIX_W-1:0] TGT_PREFIX = 4'b0100,
  parameter int                  SEL_W      = 3,
  parameter int                  REG_AW     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              sda_oe_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int ADDR_W = PREFIX_W + SEL_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  tgt_state_e        st_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q, wdata_q;
  logic [REG_AW-1:0] ptr_q, waddr_q;
  logic              in_ack_q, oe_q, rw_q, nack_q, we_q;
  logic [ADDR_W-1:0] tgt_addr;
  logic              rd_load;

  assign tgt_addr = {TGT_PREFIX, sel_i};

  // capture of the next read byte, at the fall that closes an ack clock
  assign rd_load = !start_i && !stop_i && in_ack_q && scl_fall_i &&
                   ((st_q == ST_CTRL && rw_q) || (st_q == ST_RD && !nack_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      in_ack_q  <= 1'b0;
      oe_q      <= 1'b0;
      rw_q      <= 1'b0;
      nack_q    <= 1'b0;
      ptr_q     <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      waddr_q   <= '0;
    end else begin
      we_q <= 1'b0;
      if (start_i) begin
        st_q      <= ST_CTRL;
        bit_cnt_q <= '0;
        in_ack_q  <= 1'b0;
        oe_q      <= 1'b0;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        in_ack_q <= 1'b0;
        oe_q     <= 1'b0;
      end else begin
        case (st_q)
          ST_CTRL, ST_PTR, ST_WR: begin
            if (!in_ack_q) begin
              if (scl_rise_i && bit_cnt_q < LAST_BIT) begin
                rx_q      <= {rx_q[BYTE_W-2:0], sda_i};
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end else if (scl_fall_i && bit_cnt_q == LAST_BIT) begin
                if (st_q == ST_CTRL && rx_q[BYTE_W-1:1] != tgt_addr) begin
                  st_q <= ST_IDLE;
                end else begin
                  oe_q     <= 1'b1;
                  in_ack_q <= 1'b1;
                  if (st_q == ST_CTRL) rw_q <= rx_q[0];
                end
              end
            end else if (scl_fall_i) begin
              in_ack_q  <= 1'b0;
              bit_cnt_q <= '0;
              oe_q      <= 1'b0;
              case (st_q)
                ST_CTRL: begin
                  if (rw_q) begin
                    st_q  <= ST_RD;
                    tx_q  <= reg_rdata_i;
                    oe_q  <= ~reg_rdata_i[BYTE_W-1];
                    ptr_q <= ptr_q + 1'b1;
                  end else begin
                    st_q <= ST_PTR;
                  end
                end
                ST_PTR: begin
                  ptr_q <= rx_q[REG_AW-1:0];
                  st_q  <= ST_WR;
                end
                default: begin
                  we_q    <= 1'b1;
                  wdata_q <= rx_q;
                  waddr_q <= ptr_q;
                  ptr_q   <= ptr_q + 1'b1;
                end
              endcase
            end
          end
          ST_RD: begin
            if (!in_ack_q) begin
              if (scl_rise_i && bit_cnt_q < LAST_BIT) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end else if (scl_fall_i && bit_cnt_q == LAST_BIT) begin
                oe_q     <= 1'b0;
                in_ack_q <= 1'b1;
                nack_q   <= 1'b0;
              end else if (scl_fall_i && bit_cnt_q != '0) begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q <= ~tx_q[BYTE_W-2];
              end
            end else if (scl_rise_i) begin
              nack_q <= sda_i;
            end else if (scl_fall_i) begin
              in_ack_q  <= 1'b0;
              bit_cnt_q <= '0;
              if (nack_q) begin
                st_q <= ST_IDLE;
              end else begin
                tx_q  <= reg_rdata_i;
                oe_q  <= ~reg_rdata_i[BYTE_W-1];
                ptr_q <= ptr_q + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_we_o    = we_q;
  assign reg_re_o    = rd_load;
  assign reg_wdata_o = wdata_q;
  assign reg_addr_o  = we_q ? waddr_q : ptr_q;

  AST_START_TO_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> st_q == ST_CTRL); // R1
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (st_q == ST_IDLE && !oe_q)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_IDLE |-> !oe_q && !we_q); // R2
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q); // R5
  AST_WE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> $past(in_ack_q) && $past(scl_fall_i)); // R7
  AST_NO_RW_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_q && rd_load)); // R8
  AST_OE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(scl_fall_i)); // R10
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int                  PREFIX_W    = 4,
  parameter logic [PREFIX_W-1:0] TGT_PREFIX  = 4'b0100,
  parameter int                  SEL_W       = 3,
  parameter int                  REG_AW      = 5,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [SEL_W-1:0]  addr_sel_i,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic             sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic [SEL_W-1:0] sel;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  i2c_addr_latch #(.SEL_W(SEL_W)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (addr_sel_i),
    .sel_o  (sel)
  );

  i2c_byte_engine #(
    .PREFIX_W   (PREFIX_W),
    .TGT_PREFIX (TGT_PREFIX),
    .SEL_W      (SEL_W),
    .REG_AW     (REG_AW)
  ) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_i       (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_c),
    .stop_i      (stop_c),
    .sel_i       (sel),
    .sda_oe_o    (sda_oe_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o),
    .reg_rdata_i (reg_rdata_i)
  );
endmodule

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;
  localparam int Q = 6;
  localparam logic [7:0] CTRL_W = 8'h4A; // 0100_101_0
  localparam logic [7:0] CTRL_R = 8'h4B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl = 1'b1, csda = 1'b1;
  logic oe;
  logic sda_line;
  logic [2:0] asel = 3'b101;
  logic [4:0] raddr;
  logic [7:0] wdata, rdata;
  logic we, re;
  logic [7:0] mem [32];
  logic [7:0] exp_mem [32];
  logic [7:0] wbuf [8];
  int n_tests = 0, n_fail = 0, we_cnt = 0, re_cnt = 0, oe_bad = 0;
  logic oe_prev = 1'b0;

  assign sda_line = csda & ~oe;
  assign rdata = mem[raddr];

  i2c_reg_target u0 (
    .clk_i (clk), .rst_ni (rst_n), .scl_i (scl), .sda_i (sda_line),
    .sda_oe_o (oe), .addr_sel_i (asel), .reg_addr_o (raddr),
    .reg_wdata_o (wdata), .reg_we_o (we), .reg_re_o (re), .reg_rdata_i (rdata)
  );

  always @(posedge clk) begin
    if (we) begin mem[raddr] <= wdata; we_cnt++; end
    if (re) re_cnt++;
    if (rst_n && oe !== oe_prev && scl) oe_bad++;
    oe_prev <= oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic start_c(); csda = 1; tick(Q); scl = 1; tick(Q); csda = 0; tick(Q); scl = 0; tick(Q); endtask
  task automatic stop_c(); csda = 0; tick(Q); scl = 1; tick(Q); csda = 1; tick(Q); endtask
  task automatic send_bit(input logic b); csda = b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q); endtask
  task automatic read_bit(output logic b);
    csda = 1; tick(Q); scl = 1; tick(Q); b = sda_line; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    read_bit(b);
    ack = !b;
  endtask
  task automatic rbyte(output logic [7:0] d, input logic more);
    logic b;
    for (int i = 7; i >= 0; i--) begin read_bit(b); d[i] = b; end
    send_bit(!more);
  endtask

  task automatic wr_seq(input int ptr, input int n);
    logic a;
    start_c();
    wbyte(CTRL_W, a); chk(a, "R4 ctrl ack", a, 1);
    wbyte(8'(ptr), a); chk(a, "R4 ptr ack", a, 1);
    for (int k = 0; k < n; k++) begin
      wbyte(wbuf[k], a); chk(a, "R4 data ack", a, 1);
      exp_mem[(ptr + k) % 32] = wbuf[k];
    end
    stop_c(); tick(4);
    for (int k = 0; k < n; k++)
      chk(mem[(ptr + k) % 32] == exp_mem[(ptr + k) % 32], "R5 write", mem[(ptr + k) % 32], exp_mem[(ptr + k) % 32]);
  endtask

  task automatic rd_seq(input int ptr, input int n);
    logic a;
    logic [7:0] d;
    start_c();
    wbyte(CTRL_W, a);
    wbyte(8'(ptr), a);
    start_c();
    wbyte(CTRL_R, a); chk(a, "R1 restart read ctrl ack", a, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(d, k < n - 1);
      chk(d == exp_mem[(ptr + k) % 32], "R8 read data", d, exp_mem[(ptr + k) % 32]);
    end
    stop_c();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic a, b;
    logic [7:0] d;
    int w0, r0, seed;
    seed = $urandom(32'h1C2A5);
    for (int i = 0; i < 32; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    tick(3);
    chk(oe == 0 && we == 0 && re == 0, "R10 reset quiet", {oe, we, re}, 0);
    rst_n = 1;
    tick(3);
    asel = 3'b010; // R3: must not change the match address

    // R2: address built from the new select is refused and ignored
    w0 = we_cnt;
    start_c();
    wbyte(8'h44, a); chk(!a, "R2 mismatch nack", a, 0);
    wbyte(8'h02, a); chk(!a, "R2 ignored byte", a, 0);
    wbyte(8'hEE, a); chk(!a, "R2 ignored byte", a, 0);
    stop_c(); tick(4);
    chk(we_cnt == w0, "R2 no write", we_cnt - w0, 0);

    // R3 R4 R5 directed write
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
    wr_seq(3, 2);
    // R6 wrap on write
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_seq(31, 2);
    wbuf[0] = 8'h5A;
    wr_seq(12, 1);

    // R7 stop inside a data byte
    w0 = we_cnt;
    start_c(); wbyte(CTRL_W, a); wbyte(8'd10, a); wbyte(8'h77, a);
    exp_mem[10] = 8'h77;
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    stop_c(); tick(4);
    chk(we_cnt - w0 == 1, "R7 stop cancels", we_cnt - w0, 1);
    chk(mem[11] == exp_mem[11], "R7 partial not written", mem[11], exp_mem[11]);

    // R7 restart inside a data byte, pointer must stay at 12
    w0 = we_cnt;
    start_c(); wbyte(CTRL_W, a); wbyte(8'd12, a);
    send_bit(0); send_bit(1); send_bit(1);
    start_c();
    wbyte(CTRL_R, a); chk(a, "R1 restart mid byte", a, 1);
    rbyte(d, 1'b0);
    chk(d == 8'h5A, "R7 restart keeps ptr", d, 8'h5A);
    stop_c(); tick(4);
    chk(we_cnt == w0, "R7 restart no write", we_cnt - w0, 0);

    // R8 R9 read with final nack
    r0 = re_cnt;
    start_c(); wbyte(CTRL_W, a); wbyte(8'd3, a);
    start_c(); wbyte(CTRL_R, a);
    rbyte(d, 1'b1); chk(d == 8'hA5, "R8 read byte0", d, 8'hA5);
    rbyte(d, 1'b1); chk(d == 8'h3C, "R8 read byte1", d, 8'h3C);
    rbyte(d, 1'b0); chk(d == exp_mem[5], "R8 read byte2", d, exp_mem[5]);
    chk(re_cnt - r0 == 3, "R8 read strobes", re_cnt - r0, 3);
    for (int i = 0; i < 3; i++) begin
      read_bit(b); chk(b == 1'b1, "R9 released after nack", b, 1);
    end
    stop_c();
    // R6 wrap on read
    rd_seq(31, 2);

    for (int it = 0; it < 12; it++) begin
      int p, n;
      p = $urandom % 32;
      n = 1 + $urandom % 4;
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wr_seq(p, n);
      rd_seq(p, n);
    end

    chk(oe_bad == 0, "R10 drive only while SCL low", oe_bad, 0);
    summary();
    $finish;
  end
endmodule